// File: doc/BRIEF.md
# Descriptor Queue Manager

This block holds a large set of hardware FIFO queues whose entries are descriptor pointers. A queue owns no storage of its own. Each queue is a linked list threaded through one shared link memory, and that memory has one entry for each descriptor in a configured descriptor region. Software or a DMA engine appends a descriptor to a queue by writing the queue's push/pop port. It removes the head of the queue by reading the same port. The block converts each pushed address into a descriptor index, using the region base, the descriptor size code and the descriptor count code. On a pop it converts the index back into an address.

The link entry of a descriptor records the index of the next descriptor and the 5-bit size hint that came in with the push, so a pop returns the address with its hint. A group of pending words has one bit per queue, and that bit is set while the queue holds at least one entry. A pushed address that falls outside the region is discarded and sets a sticky error output.

Access is over a single-cycle register bus. A read returns its data one cycle later, together with a one-cycle valid strobe. A small two-state bus FSM controls the response. Its states are BUS_IDLE (no response is due) and BUS_RESP (read data is driven). The transition BUS_IDLE→BUS_RESP and the transition BUS_RESP→BUS_RESP are both taken on a read access. Either state returns to BUS_IDLE in a cycle with no read.

Top module: `desc_queue_mgr`

## Requirements
- R1: After reset every queue is empty, all pending words and `dq_err` read 0, the region base register at 0x1000 reads 0, and the region control register at 0x1004 reads 0x00000002 (start 0, size code 0, count code 2, which gives 128 descriptors of 32 bytes).
- R2: A read access (`bus_sel`=1, `bus_wr`=0) gives `bus_rvalid`=1 with the data on `bus_rdata` exactly one cycle later. In every other cycle `bus_rvalid` is 0 and `bus_rdata` is 0. Writes never produce a response.
- R3: A write to the push/pop port of queue n at 0x2000 + 16·n + 0xC appends a descriptor to the tail of queue n. Bits [31:5] of the written value are the descriptor address and bits [4:0] are the size hint.
- R4: A read of the push/pop port of a non-empty queue removes the head entry and returns its address with the stored hint in bits [4:0]. Entries leave in the order they were pushed.
- R5: A read of the push/pop port of an empty queue returns 0 and changes nothing.
- R6: The pending word k at 0x90 + 4·k has bit b set exactly when queue 32·k + b is non-empty. Bits for queue numbers at or above the queue count read 0. The `q_nonempty` output carries the same per-queue state.
- R7: The descriptor index is start + ((addr − base) >> (5 + size code)). The base register holds bits [31:5]. The control register holds the start index in [31:16], the size code in [10:8] and the count code in [3:0]. A pop returns base + ((index − start) << (5 + size code)) together with the hint.
- R8: A push is discarded, and `dq_err` is set and stays set until reset, when any of these holds: the address is below the base, the offset index is not below 32 << count code, or the resulting index is not below the link memory depth.
- R9: A push followed in the very next cycle by a pop of the same queue returns the descriptor that was just pushed. A pending-word read in the cycle after a push or pop already shows the new state.
- R10: Queues are independent: interleaved pushes and pops on different queues keep the order within each queue.
- R11: A read at offset 0x0 of a queue group returns the queue's entry count.
- R12: At most one pending bit changes in a cycle, and the pending state changes only in the cycle after a bus access.
- R13: Writes to read-only or unmapped addresses have no effect. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe, one cycle after a read |
| q_nonempty | output | NUM_QUEUES (160) | Per-queue not-empty flags |
| dq_err | output | 1 | Sticky flag for a dropped out-of-region push |

## Verification
The queue counts, the pending bits and `dq_err` all change at the clock edge that samples the access, so they are due one cycle after it. Read data and its strobe are registered and are due in that same following cycle. The bench drives each access on a falling edge. On the next falling edge it compares every output with a behavioural model that it updated when it drove the access, so each result is sampled exactly one cycle after its stimulus. A write followed at once by a read exercises that one-cycle visibility directly.

// File: rtl/dqm_pkg.sv
package dqm_pkg;

    localparam int HINT_W = 5;

    localparam logic [31:0] QGRP_BASE   = 32'h0000_2000;
    localparam logic [31:0] PEND_BASE   = 32'h0000_0090;
    localparam logic [31:0] RGN_BASE_AD = 32'h0000_1000;
    localparam logic [31:0] RGN_CTRL_AD = 32'h0000_1004;

    typedef enum logic [2:0] {
        AK_NONE,
        AK_PEND,
        AK_RBASE,
        AK_RCTRL,
        AK_QCNT,
        AK_QPORT
    } acc_kind_e;

    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_state_e;

    typedef struct packed {
        logic [15:0] start;
        logic [2:0]  size_code;
        logic [3:0]  count_code;
    } region_cfg_t;

endpackage

// File: rtl/dqm_decode.sv
module dqm_decode
    import dqm_pkg::*;
#(
    parameter int NUM_QUEUES = 160,
    parameter int PEND_WORDS = 5,
    parameter int QID_W      = 8,
    parameter int PW_W       = 3
) (
    input  logic [13:0]      addr,
    output acc_kind_e        kind,
    output logic [QID_W-1:0] qid,
    output logic [PW_W-1:0]  pword
);
    localparam logic [31:0] QGRP_END = QGRP_BASE + 32'(NUM_QUEUES * 16);
    localparam logic [31:0] PEND_END = PEND_BASE + 32'(PEND_WORDS * 4);

    logic [31:0] a32;
    assign a32 = {18'd0, addr};

    always_comb begin
        kind  = AK_NONE;
        qid   = '0;
        pword = '0;
        if (a32 >= QGRP_BASE && a32 < QGRP_END) begin
            qid = QID_W'((a32 - QGRP_BASE) >> 4);
            unique case (addr[3:0])
                4'h0:    kind = AK_QCNT;
                4'hC:    kind = AK_QPORT;
                default: kind = AK_NONE;
            endcase
        end else if (a32 >= PEND_BASE && a32 < PEND_END && addr[1:0] == 2'b00) begin
            kind  = AK_PEND;
            pword = PW_W'((a32 - PEND_BASE) >> 2);
        end else if (a32 == RGN_BASE_AD) begin
            kind = AK_RBASE;
        end else if (a32 == RGN_CTRL_AD) begin
            kind = AK_RCTRL;
        end
    end
endmodule

// File: rtl/dqm_index.sv
module dqm_index
    import dqm_pkg::*;
#(
    parameter int DESC_MAX = 128,
    parameter int IDX_W    = 7
) (
    input  logic [31:0]      base,
    input  region_cfg_t      cfg,
    input  logic [31:0]      push_addr,
    output logic [IDX_W-1:0] push_idx,
    output logic             push_ok,
    input  logic [IDX_W-1:0] pop_idx,
    output logic [31:0]      pop_addr
);
    localparam logic [31:0] DESC_LIM = 32'(DESC_MAX);

    logic [3:0]  shamt;
    logic [31:0] addr_m;
    logic [31:0] offset;
    logic [31:0] num;
    logic [31:0] limit;
    logic [31:0] glob;

    always_comb begin
        shamt    = 4'd5 + {1'b0, cfg.size_code};
        addr_m   = {push_addr[31:5], 5'd0};
        offset   = addr_m - base;
        num      = offset >> shamt;
        limit    = 32'd32 << cfg.count_code;
        glob     = {16'd0, cfg.start} + num;
        push_ok  = (addr_m >= base) && (num < limit) && (glob < DESC_LIM);
        push_idx = glob[IDX_W-1:0];
        pop_addr = base + ((32'(pop_idx) - {16'd0, cfg.start}) << shamt);
    end
endmodule

// File: rtl/dqm_link_store.sv
module dqm_link_store
    import dqm_pkg::*;
#(
    parameter int NUM_QUEUES = 160,
    parameter int DESC_MAX   = 128,
    parameter int IDX_W      = 7,
    parameter int QID_W      = 8,
    parameter int CNT_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [QID_W-1:0]      q_sel,
    input  logic                  push_en,
    input  logic [IDX_W-1:0]      push_idx,
    input  logic [HINT_W-1:0]     push_hint,
    input  logic                  pop_en,
    output logic [CNT_W-1:0]      sel_cnt,
    output logic [IDX_W-1:0]      sel_head,
    output logic [HINT_W-1:0]     sel_hint,
    output logic [NUM_QUEUES-1:0] q_nonempty
);
    logic [IDX_W-1:0]  head_q [NUM_QUEUES];
    logic [IDX_W-1:0]  tail_q [NUM_QUEUES];
    logic [CNT_W-1:0]  cnt_q  [NUM_QUEUES];
    logic [IDX_W-1:0]  link_next [DESC_MAX];
    logic [HINT_W-1:0] link_hint [DESC_MAX];

    assign sel_cnt  = cnt_q[q_sel];
    assign sel_head = head_q[q_sel];
    assign sel_hint = link_hint[head_q[q_sel]];

    // queue descriptors: head, tail, count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int q = 0; q < NUM_QUEUES; q++) begin
                head_q[q] <= '0;
                tail_q[q] <= '0;
                cnt_q[q]  <= '0;
            end
        end else if (push_en) begin
            if (cnt_q[q_sel] == '0) begin
                head_q[q_sel] <= push_idx;
            end
            tail_q[q_sel] <= push_idx;
            cnt_q[q_sel]  <= cnt_q[q_sel] + 1'b1;
        end else if (pop_en && cnt_q[q_sel] != '0) begin
            head_q[q_sel] <= link_next[head_q[q_sel]];
            cnt_q[q_sel]  <= cnt_q[q_sel] - 1'b1;
        end
    end

    // shared link memory, indexed by descriptor
    always_ff @(posedge clk) begin
        if (push_en) begin
            link_hint[push_idx] <= push_hint;
            if (cnt_q[q_sel] != '0) begin
                link_next[tail_q[q_sel]] <= push_idx;
            end
        end
    end

    for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_ne
        assign q_nonempty[g] = (cnt_q[g] != '0);
    end
endmodule

// File: rtl/desc_queue_mgr.sv
module desc_queue_mgr
    import dqm_pkg::*;
#(
    parameter int NUM_QUEUES = 160,
    parameter int DESC_MAX   = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [13:0]           bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  bus_rvalid,
    output logic [NUM_QUEUES-1:0] q_nonempty,
    output logic                  dq_err
);
    localparam int IDX_W      = (DESC_MAX > 1) ? $clog2(DESC_MAX) : 1;
    localparam int CNT_W      = $clog2(DESC_MAX + 1);
    localparam int QID_W      = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1;
    localparam int PEND_WORDS = (NUM_QUEUES + 31) / 32;
    localparam int PW_W       = (PEND_WORDS > 1) ? $clog2(PEND_WORDS) : 1;
    localparam int DEF_COUNT  = (DESC_MAX >= 32) ? $clog2(DESC_MAX) - 5 : 0;

    acc_kind_e         kind;
    logic [QID_W-1:0]  qid;
    logic [PW_W-1:0]   pword;
    logic              rd_acc, wr_acc;
    logic [26:0]       base_q;
    logic [31:0]       base_full;
    region_cfg_t       cfg_q;
    logic [IDX_W-1:0]  push_idx;
    logic              push_ok;
    logic              push_en, pop_en;
    logic [IDX_W-1:0]  head_idx;
    logic [HINT_W-1:0] head_hint;
    logic [CNT_W-1:0]  sel_cnt;
    logic [31:0]       pop_addr;
    logic [31:0]       rd_mux, rd_q;
    logic [31:0]       pend_w [PEND_WORDS];
    bus_state_e        state_q, state_d;

    assign rd_acc    = bus_sel && !bus_wr;
    assign wr_acc    = bus_sel && bus_wr;
    assign base_full = {base_q, 5'd0};

    dqm_decode #(
        .NUM_QUEUES(NUM_QUEUES), .PEND_WORDS(PEND_WORDS),
        .QID_W(QID_W), .PW_W(PW_W)
    ) u_decode (
        .addr(bus_addr), .kind(kind), .qid(qid), .pword(pword)
    );

    dqm_index #(.DESC_MAX(DESC_MAX), .IDX_W(IDX_W)) u_index (
        .base(base_full), .cfg(cfg_q), .push_addr(bus_wdata),
        .push_idx(push_idx), .push_ok(push_ok),
        .pop_idx(head_idx), .pop_addr(pop_addr)
    );

    assign push_en = wr_acc && kind == AK_QPORT && push_ok;
    assign pop_en  = rd_acc && kind == AK_QPORT;

    dqm_link_store #(
        .NUM_QUEUES(NUM_QUEUES), .DESC_MAX(DESC_MAX),
        .IDX_W(IDX_W), .QID_W(QID_W), .CNT_W(CNT_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .q_sel(qid),
        .push_en(push_en), .push_idx(push_idx), .push_hint(bus_wdata[HINT_W-1:0]),
        .pop_en(pop_en), .sel_cnt(sel_cnt), .sel_head(head_idx),
        .sel_hint(head_hint), .q_nonempty(q_nonempty)
    );

    for (genvar w = 0; w < PEND_WORDS; w++) begin : g_pw
        for (genvar b = 0; b < 32; b++) begin : g_pb
            if (w * 32 + b < NUM_QUEUES) begin : g_live
                assign pend_w[w][b] = q_nonempty[w * 32 + b];
            end else begin : g_pad
                assign pend_w[w][b] = 1'b0;
            end
        end
    end

    // configuration and sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q           <= '0;
            cfg_q.start      <= '0;
            cfg_q.size_code  <= '0;
            cfg_q.count_code <= 4'(DEF_COUNT);
            dq_err           <= 1'b0;
        end else if (wr_acc) begin
            unique case (kind)
                AK_RBASE: base_q <= bus_wdata[31:5];
                AK_RCTRL: begin
                    cfg_q.start      <= bus_wdata[31:16];
                    cfg_q.size_code  <= bus_wdata[10:8];
                    cfg_q.count_code <= bus_wdata[3:0];
                end
                AK_QPORT: if (!push_ok) dq_err <= 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (kind)
            AK_PEND:  rd_mux = pend_w[pword];
            AK_RBASE: rd_mux = base_full;
            AK_RCTRL: rd_mux = {cfg_q.start, 5'd0, cfg_q.size_code, 4'd0, cfg_q.count_code};
            AK_QCNT:  rd_mux = 32'(sel_cnt);
            AK_QPORT: rd_mux = (sel_cnt != '0) ? (pop_addr | 32'(head_hint)) : '0;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else if (rd_acc) rd_q <= rd_mux;
    end

    // bus response FSM: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = BUS_IDLE;
        unique case (state_q)
            BUS_IDLE: state_d = rd_acc ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_acc ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // bus response FSM: outputs
    always_comb begin
        bus_rvalid = 1'b0;
        bus_rdata  = '0;
        unique case (state_q)
            BUS_RESP: begin
                bus_rvalid = 1'b1;
                bus_rdata  = rd_q;
            end
            BUS_IDLE: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/dqm_checker.sv
module dqm_checker #(
    parameter int NUM_QUEUES = 160
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_sel,
    input logic                  bus_wr,
    input logic [13:0]           bus_addr,
    input logic [31:0]           bus_rdata,
    input logic                  bus_rvalid,
    input logic [NUM_QUEUES-1:0] q_nonempty,
    input logic                  dq_err
);
    logic port_hit;
    int   qsel;

    always_comb begin
        port_hit = (32'(bus_addr) >= 32'h2000) &&
                   (32'(bus_addr) < 32'h2000 + 32'(NUM_QUEUES * 16)) &&
                   (bus_addr[3:0] == 4'hC);
        qsel = port_hit ? int'((32'(bus_addr) - 32'h2000) >> 4) : 0;
    end

    // R2
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);

    // R2
    no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> !bus_rvalid);

    // R2
    quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata != 32'd0) |-> bus_rvalid);

    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && port_hit && !q_nonempty[qsel]) |=> (bus_rdata == 32'd0));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_err |=> dq_err);

    // R12
    one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q_nonempty ^ $past(q_nonempty)) <= 1);

    // R12
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> $stable(q_nonempty));
endmodule

bind desc_queue_mgr dqm_checker #(.NUM_QUEUES(NUM_QUEUES)) u_dqm_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .q_nonempty(q_nonempty), .dq_err(dq_err)
);

// File: tb/desc_queue_mgr_test.sv
`timescale 1ns/1ps
module desc_queue_mgr_test;
    localparam int NQ  = 160;
    localparam int DM  = 128;
    localparam int NPW = (NQ + 31) / 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [13:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic [NQ-1:0] q_nonempty;
    logic          dq_err;

    int checks = 0;
    int errors = 0;

    logic [31:0] mq [NQ][$];
    logic [31:0] m_base = 32'd0;
    logic [15:0] m_start = 16'd0;
    logic [2:0]  m_sc = 3'd0;
    logic [3:0]  m_cc = 4'd2;
    logic        m_err = 1'b0;
    logic        exp_rvalid = 1'b0;
    logic [31:0] exp_rdata = 32'd0;

    always #2.5 clk = ~clk;

    desc_queue_mgr uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .q_nonempty(q_nonempty), .dq_err(dq_err)
    );

    function automatic logic [13:0] qport(int q);
        return 14'(32'h2000 + q * 16 + 12);
    endfunction

    function automatic logic [13:0] qcnt(int q);
        return 14'(32'h2000 + q * 16);
    endfunction

    function automatic logic [NQ-1:0] model_ne();
        logic [NQ-1:0] v = '0;
        for (int q = 0; q < NQ; q++) v[q] = (mq[q].size() != 0);
        return v;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_ne(string tag);
        logic [NQ-1:0] e = model_ne();
        checks++;
        if (q_nonempty !== e) begin
            errors++;
            $display("FAIL %s q_nonempty actual %h expected %h", tag, q_nonempty, e);
        end
    endtask

    task automatic model_push(logic [31:0] d);
        longint unsigned da, num, lim;
        int q;
        da  = longint'(d & 32'hFFFF_FFE0);
        lim = longint'(32) << m_cc;
        q   = (int'(bus_addr) - 32'h2000) / 16;
        if (da < longint'(m_base)) begin
            m_err = 1'b1;
            return;
        end
        num = (da - longint'(m_base)) >> (5 + int'(m_sc));
        if (num >= lim || longint'(m_start) + num >= longint'(DM)) begin
            m_err = 1'b1;
            return;
        end
        mq[q].push_back(32'(longint'(m_base) + (num << (5 + int'(m_sc)))) | {27'd0, d[4:0]});
    endtask

    task automatic model_access(logic wr, logic [13:0] addr, logic [31:0] d);
        int a = int'(addr);
        if (a >= 32'h2000 && a < 32'h2000 + 16 * NQ) begin
            int q = (a - 32'h2000) / 16;
            if (a % 16 == 12) begin
                if (wr) model_push(d);
                else if (mq[q].size() != 0) exp_rdata = mq[q].pop_front();
            end else if (a % 16 == 0 && !wr) begin
                exp_rdata = 32'(mq[q].size());
            end
        end else if (a >= 32'h90 && a < 32'h90 + 4 * NPW && a % 4 == 0) begin
            if (!wr) begin
                int w = (a - 32'h90) / 4;
                for (int b = 0; b < 32; b++)
                    if (w * 32 + b < NQ && mq[w * 32 + b].size() != 0) exp_rdata[b] = 1'b1;
            end
        end else if (a == 32'h1000) begin
            if (wr) m_base = d & 32'hFFFF_FFE0;
            else exp_rdata = m_base;
        end else if (a == 32'h1004) begin
            if (wr) begin
                m_start = d[31:16];
                m_sc    = d[10:8];
                m_cc    = d[3:0];
            end else begin
                exp_rdata = {m_start, 5'd0, m_sc, 4'd0, m_cc};
            end
        end
    endtask

    // one bus cycle: compare the previous cycle's results, then drive the next
    task automatic step(string tag, logic sel, logic wr, logic [13:0] addr, logic [31:0] d);
        @(negedge clk);
        check(tag, "rvalid", 32'(bus_rvalid), 32'(exp_rvalid));
        check(tag, "rdata", bus_rdata, exp_rdata);
        check(tag, "dq_err", 32'(dq_err), 32'(m_err));
        check_ne(tag);
        bus_sel    = sel;
        bus_wr     = wr;
        bus_addr   = addr;
        bus_wdata  = d;
        exp_rvalid = sel && !wr;
        exp_rdata  = 32'd0;
        if (sel) model_access(wr, addr, d);
    endtask

    task automatic wr(string tag, logic [13:0] a, logic [31:0] d);
        step(tag, 1'b1, 1'b1, a, d);
    endtask

    task automatic rd(string tag, logic [13:0] a);
        step(tag, 1'b1, 1'b0, a, 32'd0);
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 1'b0, 1'b0, 14'd0, 32'd0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog run did not complete actual 0 expected 1");
        finish_run();
    end

    initial begin
        logic [31:0] b;
        repeat (3) @(negedge clk);
        // R1 outputs held at zero during reset
        check("R1", "rvalid in reset", 32'(bus_rvalid), 32'd0);
        check("R1", "dq_err in reset", 32'(dq_err), 32'd0);
        check_ne("R1");
        rst_n = 1'b1;

        // R1 reset register values
        rd("R1", 14'h1004);
        rd("R1", 14'h1000);
        for (int w = 0; w < NPW; w++) rd("R1", 14'(32'h90 + 4 * w));
        // R5 pop of an empty queue
        rd("R5", qport(0));
        idle("R1", 1);

        // R13 unmapped and read-only accesses
        wr("R13", 14'h1008, 32'hFFFF_FFFF);
        rd("R13", 14'h1008);
        wr("R13", qcnt(3), 32'h4000_0020);
        rd("R13", qcnt(3));
        wr("R13", 14'(32'h2004 + 3 * 16), 32'h4000_0020);
        rd("R13", qport(3));
        wr("R13", 14'h0090, 32'hFFFF_FFFF);
        rd("R13", 14'h0090);

        // R7 region base
        b = 32'h4001_0000;
        wr("R7", 14'h1000, b);
        rd("R7", 14'h1000);

        // R3 R4 R11 push three descriptors to queue 5, pop in order
        wr("R3", qport(5), b + 32'h20 + 32'h3);
        wr("R3", qport(5), b + 32'h100 + 32'h1F);
        wr("R3", qport(5), b + 32'h7E0);
        rd("R11", qcnt(5));
        rd("R4", qport(5));
        rd("R4", qport(5));
        rd("R11", qcnt(5));
        rd("R4", qport(5));
        rd("R5", qport(5));
        rd("R11", qcnt(5));

        // R6 pending words, read straight after the change
        wr("R6", qport(31), b + 32'h40);
        rd("R6", 14'h0090);
        wr("R6", qport(32), b + 32'h60);
        wr("R6", qport(NQ - 1), b + 32'h80 + 32'h7);
        rd("R6", 14'(32'h90 + 4 * (NPW - 1)));
        rd("R6", 14'h0094);
        rd("R6", 14'h0090);
        rd("R6", qport(31));
        rd("R6", 14'h0090);
        rd("R6", qport(32));
        rd("R6", qport(NQ - 1));
        rd("R6", 14'(32'h90 + 4 * (NPW - 1)));

        // R9 push then immediate pop of the same queue
        wr("R9", qport(7), b + 32'hA0 + 32'h9);
        rd("R9", qport(7));
        wr("R9", qport(7), b + 32'hC0);
        wr("R9", qport(7), b + 32'hE0 + 32'h2);
        rd("R9", qport(7));
        rd("R9", qport(7));

        // R10 interleaved queues
        wr("R10", qport(1), b + 32'h200 + 32'h1);
        wr("R10", qport(2), b + 32'h220 + 32'h2);
        wr("R10", qport(1), b + 32'h240 + 32'h3);
        wr("R10", qport(2), b + 32'h260 + 32'h4);
        rd("R10", qport(2));
        rd("R10", qport(1));
        wr("R10", qport(1), b + 32'h280 + 32'h5);
        rd("R10", qport(2));
        rd("R10", qport(1));
        rd("R10", qport(1));
        rd("R10", qport(1));

        // R8 out-of-region pushes
        wr("R8", qport(9), b - 32'h20);
        idle("R8", 2);
        wr("R8", qport(9), b + 32'(DM * 32));
        rd("R8", qcnt(9));

        // R7 R8 start index, 64-byte descriptors, 32 of them
        wr("R7", 14'h1004, 32'h0078_0100);
        rd("R7", 14'h1004);
        wr("R8", qport(9), b + 32'(10 * 64));
        wr("R8", qport(9), b + 32'(40 * 64));
        wr("R7", qport(9), b + 32'(3 * 64) + 32'h5);
        wr("R7", qport(9), b + 32'(7 * 64) + 32'h1);
        rd("R11", qcnt(9));
        rd("R7", qport(9));
        rd("R7", qport(9));
        rd("R5", qport(9));
        idle("R12", 4);
        finish_run();
    end
endmodule